// File: doc/BRIEF.md
# Sliding-Window Signed Maximum

The block watches a stream of 16-bit two's-complement samples and reports the largest value among the most recent `DEPTH` accepted samples (default 512). Anything older than that window has no effect on the result, even if it was larger. The samples sit in a circular buffer built as an inferable memory with one write port and one registered read port. Comparisons are therefore made one at a time rather than by a wide comparator tree.

Each accepted sample is written over the oldest entry. A controller then walks every buffer address, one per cycle. A pipelined comparator keeps a running maximum, which starts from the most negative code for each pass. At the end of the pass the result is loaded into the output register and a one-cycle flag is raised. A sample that arrives during a pass waits in a single holding register and is written as soon as the pass ends.

After reset a sweep of `DEPTH` cycles writes zero to every entry, so the window initially reads as all zeros. Samples strobed during that sweep are discarded.

Top module: `win_max_scan`

## Requirements
- R1: While reset is high and at the first clock edge after it, `max_out` is 0x0000 and `max_valid` is 0.
- R2: Samples strobed during the first `DEPTH` clock edges after reset is released are discarded. Every buffer entry reads as zero until overwritten by an accepted sample.
- R3: Samples are compared as signed 16-bit values, so 0x0001 ranks above 0xFFFD, which ranks above 0x8000.
- R4: A published maximum is the largest of exactly the last `DEPTH` accepted samples, counting the one that started the pass. A sample older than that is excluded however large it is.
- R5: A sample accepted at clock edge E causes `max_out` to load its new value and `max_valid` to rise at edge E+`DEPTH`+1. `max_valid` stays high for exactly one cycle.
- R6: `max_out` changes only in the cycle in which `max_valid` is high, and holds its value otherwise.
- R7: A sample strobed while a pass is in progress is held and written at the first edge after that pass publishes. That write starts a new pass, so no sample is lost while strobes are at least `DEPTH`+3 cycles apart.
- R8: A new pass starts only when no pass is in progress. If two strobes arrive during one pass, only the later one is held; each accepted sample starts exactly one pass.
- R9: The running maximum starts each pass at 0x8000, so a window holding only 0x8000 publishes 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Strobe qualifying `smp_data` for one cycle |
| smp_data | input | 16 | Sample, two's complement |
| max_out | output | 16 | Last published window maximum, two's complement |
| max_valid | output | 1 | One-cycle pulse when `max_out` is reloaded |

## Verification
The assertions assume that reset is held for at least two clock edges, so the output register has a defined value before the hold and pulse properties begin to look back one cycle. They also assume that `smp_valid` and `smp_data` are never unknown outside reset. The latency and pass-exclusion properties depend only on the block's own handshake. They still hold when strobes arrive faster than the no-loss rate, because the holding register simply keeps the newest sample.

The stimulus uses a 16-entry window, so the window can be filled and aged out many times within a short run. It drives every input on the falling edge and keeps `smp_valid` at a known level at all times. Gaps between strobes are sometimes shorter than one pass, which deliberately exercises the holding and replacement behaviour.

// File: rtl/wmax_pkg.sv
package wmax_pkg;

  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SCAN  = 2'd2,
    ST_DRAIN = 2'd3
  } ctrl_st_e;

  // Circular increment: returns 0 after lim-1.
  function automatic int wrap_inc(input int v, input int lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Signed greater-than on sign-extended operands.
  function automatic bit sgt(input logic signed [63:0] a, input logic signed [63:0] b);
    return a > b;
  endfunction

endpackage

// File: rtl/wmax_ram.sv
module wmax_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rd
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rd <= mem[ra];
  end

endmodule

// File: rtl/wmax_ctrl.sv
module wmax_ctrl
  import wmax_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              we,
  output logic [ADDR_W-1:0] wa,
  output logic [DATA_W-1:0] wd,
  output logic              re,
  output logic [ADDR_W-1:0] ra,
  output logic              rd_last,
  output logic              accept,
  output logic              init_done
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  ctrl_st_e          state;
  logic [ADDR_W-1:0] init_cnt;
  logic [ADDR_W-1:0] scan_cnt;
  logic [ADDR_W-1:0] wr_ptr;
  logic              skid_full;
  logic [DATA_W-1:0] skid_data;
  logic              in_init;
  logic              busy;

  assign in_init   = (state == ST_INIT);
  assign init_done = !in_init;
  assign busy      = (state == ST_SCAN) || (state == ST_DRAIN);
  assign accept    = (state == ST_IDLE) && (skid_full || smp_valid);

  assign we      = in_init || accept;
  assign wa      = in_init ? init_cnt : wr_ptr;
  assign wd      = in_init ? '0 : (skid_full ? skid_data : smp_data);
  assign re      = (state == ST_SCAN);
  assign ra      = scan_cnt;
  assign rd_last = re && (scan_cnt == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT;
      init_cnt  <= '0;
      scan_cnt  <= '0;
      wr_ptr    <= '0;
      skid_full <= 1'b0;
      skid_data <= '0;
    end else begin
      case (state)
        ST_INIT: begin
          init_cnt <= ADDR_W'(wrap_inc(int'(init_cnt), DEPTH));
          if (init_cnt == LAST_ADDR) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (accept) begin
            wr_ptr   <= ADDR_W'(wrap_inc(int'(wr_ptr), DEPTH));
            scan_cnt <= '0;
            state    <= ST_SCAN;
          end
          if (skid_full) begin
            skid_full <= smp_valid;
            if (smp_valid) skid_data <= smp_data;
          end
        end
        ST_SCAN: begin
          scan_cnt <= ADDR_W'(wrap_inc(int'(scan_cnt), DEPTH));
          if (scan_cnt == LAST_ADDR) state <= ST_DRAIN;
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
      if (busy && smp_valid) begin
        skid_full <= 1'b1;
        skid_data <= smp_data;
      end
    end
  end

endmodule

// File: rtl/wmax_reduce.sv
module wmax_reduce
  import wmax_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_issue,
  input  logic              rd_issue_last,
  input  logic [DATA_W-1:0] rd_data,
  output logic              publish,
  output logic [DATA_W-1:0] max_out,
  output logic              max_valid
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic              dv_q;
  logic              last_q;
  logic [DATA_W-1:0] run_max;
  logic [DATA_W-1:0] cand;

  assign cand    = sgt(64'(signed'(rd_data)), 64'(signed'(run_max))) ? rd_data : run_max;
  assign publish = dv_q && last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q      <= 1'b0;
      last_q    <= 1'b0;
      run_max   <= MOST_NEG;
      max_out   <= '0;
      max_valid <= 1'b0;
    end else begin
      dv_q      <= rd_issue;
      last_q    <= rd_issue_last;
      max_valid <= 1'b0;
      if (start) begin
        run_max <= MOST_NEG;
      end else if (dv_q) begin
        if (last_q) begin
          max_out   <= cand;
          max_valid <= 1'b1;
          run_max   <= MOST_NEG;
        end else begin
          run_max <= cand;
        end
      end
    end
  end

endmodule

// File: rtl/win_max_scan.sv
module win_max_scan #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic [DATA_W-1:0] max_out,
  output logic              max_valid
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              we;
  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] wd;
  logic              re;
  logic [ADDR_W-1:0] ra;
  logic [DATA_W-1:0] rd;
  logic              rd_last;
  logic              accept;
  logic              init_done;
  logic              publish;

  wmax_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .we        (we),
    .wa        (wa),
    .wd        (wd),
    .re        (re),
    .ra        (ra),
    .rd_last   (rd_last),
    .accept    (accept),
    .init_done (init_done)
  );

  wmax_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk (clk),
    .we  (we),
    .wa  (wa),
    .wd  (wd),
    .re  (re),
    .ra  (ra),
    .rd  (rd)
  );

  wmax_reduce #(.DATA_W(DATA_W)) u_reduce (
    .clk           (clk),
    .rst           (rst),
    .start         (accept),
    .rd_issue      (re),
    .rd_issue_last (rd_last),
    .rd_data       (rd),
    .publish       (publish),
    .max_out       (max_out),
    .max_valid     (max_valid)
  );

endmodule

// File: rtl/wmax_chk.sv
module wmax_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              accept,
  input logic              init_done,
  input logic              publish,
  input logic [DATA_W-1:0] max_out,
  input logic              max_valid
);

  logic        rst_q;
  logic        pass_open;
  logic [31:0] since_acc;

  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      AST_RESET_CLEAR: assert (max_out == '0 && !max_valid)
        else $error("output not cleared by reset"); // R1
    end
    rst_q <= rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_open <= 1'b0;
      since_acc <= '0;
    end else begin
      if (accept) pass_open <= 1'b1;
      else if (max_valid) pass_open <= 1'b0;
      if (accept) since_acc <= '0;
      else if (since_acc != '1) since_acc <= since_acc + 32'd1;
    end
  end

  AST_INIT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !accept); // R2

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    max_valid |=> !max_valid); // R5

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    max_valid |-> (since_acc == 32'(DEPTH + 1))); // R5

  AST_PUBLISH_LEADS: assert property (@(posedge clk) disable iff (rst)
    publish |=> max_valid); // R5

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    !max_valid |-> $stable(max_out)); // R6

  AST_ONE_PASS: assert property (@(posedge clk) disable iff (rst)
    accept |-> (!pass_open || max_valid)); // R8

endmodule

bind win_max_scan wmax_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .accept    (accept),
  .init_done (init_done),
  .publish   (publish),
  .max_out   (max_out),
  .max_valid (max_valid)
);

// File: tb/win_max_scan_bench.sv
module win_max_scan_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int LAT        = DEPTH + 1;
  localparam int WD_CYCLES  = 60000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic [15:0] max_out;
  logic        max_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_max_scan #(.DATA_W(16), .DEPTH(DEPTH)) u_win_max_scan (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .max_out   (max_out),
    .max_valid (max_valid)
  );

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 0;

  // Behavioural reference model
  int          win[$];
  int          init_left = DEPTH;
  int          busy = 0;
  int          snap = 0;
  int          skid_v = 0;
  bit          pend = 0;
  logic [15:0] exp_max = '0;
  bit          exp_vld = 0;

  function void take(input int v);
    win.push_back(v);
    void'(win.pop_front());
    snap = -32768;
    foreach (win[i]) if (win[i] > snap) snap = win[i];
    busy = LAT;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      win.delete();
      for (int i = 0; i < DEPTH; i++) win.push_back(0);
      init_left = DEPTH;
      busy = 0; pend = 0; exp_max = '0; exp_vld = 0;
    end else begin
      exp_vld = 0;
      if (init_left > 0) begin
        init_left--;
      end else if (busy == 0) begin
        if (pend) begin
          take(skid_v);
          pend = smp_valid;
          if (smp_valid) skid_v = int'($signed(smp_data));
        end else if (smp_valid) begin
          take(int'($signed(smp_data)));
        end
      end else begin
        if (smp_valid) begin
          pend = 1;
          skid_v = int'($signed(smp_data));
        end
        busy--;
        if (busy == 0) begin
          exp_max = 16'(snap);
          exp_vld = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(max_valid === exp_vld, "R5 pulse timing", int'(max_valid), int'(exp_vld));
      chk(max_out === exp_max, exp_vld ? "R4 window value" : "R6 output hold",
          int'($signed(max_out)), int'($signed(exp_max)));
      if (max_valid === 1'b1) pulses++;
    end
  end

  task automatic send(input logic [15:0] d, input int gap);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = d;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic expect_max(input logic [15:0] e, input string tag);
    chk(max_out === e, tag, int'($signed(max_out)), int'($signed(e)));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk(max_out === 16'h0000, "R1 reset value", int'(max_out), 0);
    chk(max_valid === 1'b0, "R1 reset flag", int'(max_valid), 0);
    rst = 1'b0;
    // Strobes during the clearing sweep must be discarded (R2)
    smp_valid = 1'b1;
    smp_data  = 16'h7FFF;
    repeat (10) @(negedge clk);
    smp_valid = 1'b0;
    repeat (DEPTH) @(negedge clk);

    send(16'hFFFB, LAT + 3);
    expect_max(16'h0000, "R2 zeros remain, init strobes ignored");

    send(16'h7000, LAT + 3);
    expect_max(16'h7000, "R4 new largest");
    for (int i = 0; i < DEPTH - 1; i++) send(16'h8000, LAT + 3);
    expect_max(16'h7000, "R4 oldest still inside window");
    send(16'h8000, LAT + 3);
    expect_max(16'h8000, "R9 all most-negative window");

    send(16'h0001, LAT + 3);
    expect_max(16'h0001, "R3 signed above 0x8000");
    send(16'hFFFD, LAT + 3);
    expect_max(16'h0001, "R3 0x0001 beats 0xFFFD");

    // Held sample during a pass (R7)
    p0 = pulses;
    send(16'h0100, 4);
    send(16'h0200, 2 * LAT + 4);
    chk(pulses - p0 == 2, "R7 held sample scanned", pulses - p0, 2);
    expect_max(16'h0200, "R7 held sample value");

    // Two strobes in one pass: later one replaces the held one (R8)
    p0 = pulses;
    send(16'h0300, 2);
    send(16'h0050, 2);
    send(16'h0060, 3 * LAT);
    chk(pulses - p0 == 2, "R8 one pass per accepted sample", pulses - p0, 2);
    expect_max(16'h0300, "R8 window after replacement");

    for (int i = 0; i < 200; i++) send(16'($urandom), $urandom_range(0, 30));
    repeat (3 * LAT) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule